// File: doc/BRIEF.md
# Dilated Crossbar Output Allocator

This block decides which physical output of an eight-port, byte-wide crossbar a newly opening connection takes. Each input raises a one-cycle open strobe together with the connection's first byte; the top two bits of that byte name a logical direction. A mode input selects how the eight outputs are grouped. In dilated mode the part acts as one radix-4 router in which every direction owns two equivalent outputs. In dual mode it acts as two radix-4 routers, each with one output per direction. Inputs 0 to 3 belong to the first router and inputs 4 to 7 to the second.

When a direction offers two usable outputs, the block reads the downstream busy hint of each one. The hint arrives through a pipeline and may be out of date, so it only breaks a tie. When both hints agree, the choice comes from a free-running LFSR. Disabled outputs, disabled inputs and outputs already held by a live connection are never handed out. The block registers the grant together with a crosspoint select for each output: a used flag and the index of the input that drives it. A connection holds its output until its input raises a close strobe.

Top module: `dil_alloc`

## Requirements
- R1: The direction is bits [7:6] of the byte on `in_head` for an input, sampled on the clock edge where that input's `in_open` is high. The lower six bits have no effect.
- R2: In dilated mode (`dil2_mode`=1), direction d may use outputs 2d and 2d+1. In dual mode (`dil2_mode`=0), direction d maps to output d for inputs 0 to 3 and to output 4+d for inputs 4 to 7.
- R3: In dilated mode, when both candidate outputs are usable and exactly one has `out_busy` set, the connection takes the other one.
- R4: In dilated mode, when both candidates are usable and their busy hints are equal, LFSR bit 0 picks the output: 0 selects 2d and 1 selects 2d+1.
- R5: An output with `out_dis` set is never allocated, whatever the busy hints say. A lone usable candidate is taken even if it is busy.
- R6: An input with `in_dis` set never receives a grant.
- R7: If no candidate output is usable (disabled or held), the request is refused. No grant is given and the request is not kept.
- R8: Requests in the same cycle are served from input 0 upward. A lower input's pick removes that output from the candidates of the higher inputs.
- R9: An allocated output stays used, with its source unchanged, until the owning input's `in_close` is sampled. It is free after that edge. An input holding a connection gets no grant for a new open, and an output freed on an edge cannot be granted on that same edge.
- R10: The LFSR resets to 8'h01 and advances each cycle as {s[6:0], s7^s5^s4^s3}. When `seed_load` is high, it loads `seed_val` instead, and a zero seed is replaced by 8'h01.
- R11: `grant` is a one-cycle pulse, one clock after the open strobe. `out_used` and `out_src` update on that same edge. All three are zero after reset.
- R12: In dual mode the busy hints have no effect on allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dil2_mode | input | 1 | 1: one dilation-2 router, 0: two dilation-1 routers |
| in_open | input | 8 | Per-input connection open strobe |
| in_head | input | 64 | First byte per input, input i at bits [8i+7:8i] |
| in_close | input | 8 | Per-input connection close strobe |
| in_dis | input | 8 | Per-input disable |
| out_dis | input | 8 | Per-output disable |
| out_busy | input | 8 | Per-output advisory downstream busy hint |
| seed_load | input | 1 | Load the LFSR from seed_val |
| seed_val | input | 8 | LFSR seed |
| grant | output | 8 | Per-input grant pulse |
| out_used | output | 8 | Per-output crosspoint enabled |
| out_src | output | 24 | Per-output driving input index, output o at bits [3o+2:3o] |

## Verification
The bench targets these corner cases:
- **Lone busy candidate.** When the only free candidate is busy, the block must still take it. A design that treated the hint as binding would refuse here.
- **Same-cycle collision.** Three inputs request one direction in the same cycle. A broken priority chain would give two inputs the same output or starve the wrong input.
- **Close and reopen on one edge.** A design that freed outputs before allocating would hand a closing output to a new input on that same edge.
- **Held input reopens.** A held input that opens again must get no grant; a faulty design would grant it a second output.
- **Zero seed.** Loading a zero seed must yield 8'h01. A design that skipped this check would lock the LFSR at zero and always pick the lower output.

Long runs with random stimulus compare every grant and crosspoint select against a behavioural model.

// File: rtl/dil_alloc_pkg.sv
package dil_alloc_pkg;

   typedef enum logic {
      ORG_DUAL    = 1'b0,
      ORG_DILATED = 1'b1
   } org_e;

   localparam int unsigned RNG_BITS = 8;

   // x^8 + x^6 + x^5 + x^4 + 1, shifting toward the MSB
   function automatic logic [RNG_BITS-1:0] rng_advance(input logic [RNG_BITS-1:0] s);
      return {s[RNG_BITS-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

endpackage

// File: rtl/dra_lfsr.sv
module dra_lfsr
   import dil_alloc_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);

   localparam logic [W-1:0] NONZERO = W'(1);

   if (W != RNG_BITS) begin : g_bad_width
      $error("dra_lfsr: only the package polynomial width is supported");
   end

   logic [W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= NONZERO;
      else if (load)
         state_q <= (seed == '0) ? NONZERO : seed;
      else
         state_q <= rng_advance(state_q);
   end

   assign state = state_q;

   a_r10_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

endmodule

// File: rtl/dra_pick.sv
module dra_pick
   import dil_alloc_pkg::*;
#(
   parameter int unsigned RADIX = 4,
   parameter int unsigned N_OUT = 2 * RADIX,
   parameter int unsigned DIR_W = $clog2(RADIX),
   parameter int unsigned IDX_W = $clog2(N_OUT)
) (
   input  org_e             org,
   input  logic [DIR_W-1:0] dir,
   input  logic             upper_half,
   input  logic [N_OUT-1:0] avail,
   input  logic [N_OUT-1:0] busy,
   input  logic             coin,
   output logic             ok,
   output logic [IDX_W-1:0] port
);

   logic [IDX_W-1:0] lo_p, hi_p, flat_p;
   logic             lo_ok, hi_ok;

   always_comb begin
      lo_p   = IDX_W'({dir, 1'b0});
      hi_p   = lo_p | IDX_W'(1);
      flat_p = upper_half ? IDX_W'(RADIX) + IDX_W'(dir) : IDX_W'(dir);
      lo_ok  = avail[lo_p];
      hi_ok  = avail[hi_p];
      ok     = 1'b0;
      port   = lo_p;
      if (org == ORG_DILATED) begin
         if (lo_ok && hi_ok) begin
            ok = 1'b1;
            if (busy[lo_p] && !busy[hi_p])
               port = hi_p;
            else if (busy[hi_p] && !busy[lo_p])
               port = lo_p;
            else
               port = coin ? hi_p : lo_p;
         end else if (lo_ok) begin
            ok   = 1'b1;
            port = lo_p;
         end else if (hi_ok) begin
            ok   = 1'b1;
            port = hi_p;
         end
      end else begin
         port = flat_p;
         ok   = avail[flat_p];
      end
   end

endmodule

// File: rtl/dil_alloc.sv
module dil_alloc
   import dil_alloc_pkg::*;
#(
   parameter int unsigned N_PORTS = 8,
   parameter int unsigned RADIX   = 4,
   parameter int unsigned HEAD_W  = 8,
   parameter int unsigned RNG_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dil2_mode,
   input  logic [N_PORTS-1:0]          in_open,
   input  logic [N_PORTS*HEAD_W-1:0]   in_head,
   input  logic [N_PORTS-1:0]          in_close,
   input  logic [N_PORTS-1:0]          in_dis,
   input  logic [N_PORTS-1:0]          out_dis,
   input  logic [N_PORTS-1:0]          out_busy,
   input  logic                        seed_load,
   input  logic [RNG_W-1:0]            seed_val,
   output logic [N_PORTS-1:0]          grant,
   output logic [N_PORTS-1:0]          out_used,
   output logic [N_PORTS*$clog2(N_PORTS)-1:0] out_src
);

   localparam int unsigned IDX_W = $clog2(N_PORTS);
   localparam int unsigned DIR_W = $clog2(RADIX);
   localparam int unsigned LOW_W = HEAD_W - DIR_W;

   if (N_PORTS != 2 * RADIX) begin : g_bad_ports
      $error("dil_alloc: port count must be twice the radix");
   end
   if ((1 << DIR_W) != RADIX) begin : g_bad_radix
      $error("dil_alloc: radix must be a power of two");
   end
   if (HEAD_W <= DIR_W) begin : g_bad_head
      $error("dil_alloc: header byte too narrow for the direction field");
   end

   org_e                 org;
   logic [RNG_W-1:0]     rng;
   logic [N_PORTS-1:0]   held_q, used_q, grant_q;
   logic [IDX_W-1:0]     src_q [N_PORTS];
   logic [N_PORTS-1:0]   avail_c [N_PORTS+1];
   logic [N_PORTS-1:0]   pk_ok, win, release_o;
   logic [IDX_W-1:0]     pk_port [N_PORTS];
   logic [N_PORTS-1:0]   claim;
   logic [IDX_W-1:0]     claim_src [N_PORTS];
   logic [N_PORTS*LOW_W-1:0] unused_head_low;
   logic                 unused_rng_high;

   assign org = dil2_mode ? ORG_DILATED : ORG_DUAL;

   dra_lfsr #(.W(RNG_W)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_load),
      .seed  (seed_val),
      .state (rng)
   );

   assign unused_rng_high = ^rng[RNG_W-1:1];

   // Chain of free outputs: each input sees what lower inputs left over
   assign avail_c[0] = ~used_q & ~out_dis;

   for (genvar i = 0; i < N_PORTS; i++) begin : g_in
      logic [DIR_W-1:0] dir;
      assign dir = in_head[i*HEAD_W + LOW_W +: DIR_W];
      assign unused_head_low[i*LOW_W +: LOW_W] = in_head[i*HEAD_W +: LOW_W];

      dra_pick #(
         .RADIX (RADIX),
         .N_OUT (N_PORTS),
         .DIR_W (DIR_W),
         .IDX_W (IDX_W)
      ) u_pick (
         .org        (org),
         .dir        (dir),
         .upper_half (i >= RADIX),
         .avail      (avail_c[i]),
         .busy       (out_busy),
         .coin       (rng[0]),
         .ok         (pk_ok[i]),
         .port       (pk_port[i])
      );

      assign win[i] = in_open[i] & ~in_dis[i] & ~held_q[i] & pk_ok[i];
      assign avail_c[i+1] = avail_c[i] &
                            ~(win[i] ? (N_PORTS'(1) << pk_port[i]) : '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_q[i]  <= 1'b0;
            grant_q[i] <= 1'b0;
         end else begin
            grant_q[i] <= win[i];
            if (win[i])
               held_q[i] <= 1'b1;
            else if (in_close[i])
               held_q[i] <= 1'b0;
         end
      end

      a_r6_no_grant_disabled_in: assert property (@(posedge clk) disable iff (!rst_n)
         grant_q[i] |-> !$past(in_dis[i]));
      a_r9_no_grant_while_held: assert property (@(posedge clk) disable iff (!rst_n)
         grant_q[i] |-> !$past(held_q[i]));
   end

   always_comb begin
      claim = '0;
      for (int o = 0; o < N_PORTS; o++) claim_src[o] = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (win[i]) begin
            claim[pk_port[i]]     = 1'b1;
            claim_src[pk_port[i]] = IDX_W'(i);
         end
      end
   end

   for (genvar o = 0; o < N_PORTS; o++) begin : g_out
      assign release_o[o] = used_q[o] & in_close[src_q[o]];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            used_q[o] <= 1'b0;
            src_q[o]  <= '0;
         end else if (release_o[o]) begin
            used_q[o] <= 1'b0;
         end else if (claim[o]) begin
            used_q[o] <= 1'b1;
            src_q[o]  <= claim_src[o];
         end
      end

      assign out_src[o*IDX_W +: IDX_W] = src_q[o];

      a_r5_disabled_out_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(used_q[o]) |-> !$past(out_dis[o]));
      a_r9_free_only_on_close: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(used_q[o]) |-> $past(in_close[src_q[o]]));
      a_r9_source_held: assert property (@(posedge clk) disable iff (!rst_n)
         (used_q[o] && $past(used_q[o])) |-> $stable(src_q[o]));
   end

   a_r11_grant_matches_claims: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_q) == $countones(used_q & ~$past(used_q)));

   assign grant    = grant_q;
   assign out_used = used_q;

endmodule

// File: tb/dil_alloc_test.sv
`timescale 1ns/1ps
module dil_alloc_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dil2_mode;
   logic [7:0]  in_open, in_close, in_dis, out_dis, out_busy;
   logic [63:0] in_head;
   logic        seed_load;
   logic [7:0]  seed_val;
   logic [7:0]  grant, out_used;
   logic [23:0] out_src;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [7:0] m_used, m_held, m_grant, m_rng;
   int         m_src [8];

   always #2 clk = ~clk;

   dil_alloc uut (
      .clk(clk), .rst_n(rst_n), .dil2_mode(dil2_mode), .in_open(in_open),
      .in_head(in_head), .in_close(in_close), .in_dis(in_dis), .out_dis(out_dis),
      .out_busy(out_busy), .seed_load(seed_load), .seed_val(seed_val),
      .grant(grant), .out_used(out_used), .out_src(out_src)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   function automatic int src_of(input int o);
      return int'(out_src[o*3 +: 3]);
   endfunction

   task automatic compare_model();
      chk("R11 grant pulse", {24'd0, grant}, {24'd0, m_grant});
      chk("R9 used outputs", {24'd0, out_used}, {24'd0, m_used});
      for (int o = 0; o < 8; o++)
         if (m_used[o]) chk("R2 crosspoint source", src_of(o), m_src[o]);
   endtask

   // one clock: model computes from present inputs, DUT clocks, compare after edge
   task automatic tick();
      logic [7:0] av, ng, nu, nh, nr;
      int ns [8];
      av = ~m_used & ~out_dis;
      ng = '0; nu = m_used; nh = m_held;
      for (int o = 0; o < 8; o++) ns[o] = m_src[o];
      for (int o = 0; o < 8; o++)
         if (m_used[o] && in_close[m_src[o]]) nu[o] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (m_held[i] && in_close[i]) nh[i] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (in_open[i] && !in_dis[i] && !m_held[i]) begin
            int d, p, a, b;
            d = int'(in_head[i*8+6 +: 2]);
            p = -1;
            if (dil2_mode) begin
               a = 2*d; b = 2*d + 1;
               if (av[a] && av[b]) begin
                  if (out_busy[a] && !out_busy[b])      p = b;
                  else if (out_busy[b] && !out_busy[a]) p = a;
                  else                                  p = m_rng[0] ? b : a;
               end else if (av[a]) p = a;
               else if (av[b])     p = b;
            end else begin
               a = (i >= 4 ? 4 : 0) + d;
               if (av[a]) p = a;
            end
            if (p >= 0) begin
               av[p] = 1'b0; ng[i] = 1'b1; nu[p] = 1'b1; ns[p] = i; nh[i] = 1'b1;
            end
         end
      end
      if (seed_load) nr = (seed_val == 8'h00) ? 8'h01 : seed_val;
      else           nr = {m_rng[6:0], m_rng[7] ^ m_rng[5] ^ m_rng[4] ^ m_rng[3]};
      @(posedge clk);
      @(negedge clk);
      m_grant = ng; m_used = nu; m_held = nh; m_rng = nr;
      for (int o = 0; o < 8; o++) m_src[o] = ns[o];
      compare_model();
   endtask

   task automatic idle_inputs();
      in_open = '0; in_close = '0; seed_load = 1'b0;
   endtask

   task automatic close_all();
      idle_inputs();
      in_close = 8'hFF;
      tick();
      in_close = '0;
   endtask

   task automatic open1(input int i, input logic [7:0] head);
      in_open[i] = 1'b1;
      in_head[i*8 +: 8] = head;
   endtask

   initial begin
      #(4 * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; dil2_mode = 1'b1; in_open = '0; in_close = '0; in_head = '0;
      in_dis = '0; out_dis = '0; out_busy = '0; seed_load = 1'b0; seed_val = '0;
      m_used = '0; m_held = '0; m_grant = '0; m_rng = 8'h01;
      for (int o = 0; o < 8; o++) m_src[o] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 reset grant", {24'd0, grant}, 32'h0);
      chk("R11 reset used", {24'd0, out_used}, 32'h0);

      // R3: exactly one busy, take the idle one
      out_busy = 8'h01; open1(0, 8'h00); tick();
      chk("R3 idle port chosen", {31'd0, out_used[1]}, 32'd1);
      chk("R3 source of port 1", src_of(1), 32'd0);
      chk("R11 grant one cycle later", {24'd0, grant}, 32'h01);
      idle_inputs(); tick();
      chk("R11 grant is a pulse", {24'd0, grant}, 32'h0);
      // R5: lone candidate taken although busy
      open1(1, 8'h00); tick();
      chk("R5 lone busy candidate taken", src_of(0), 32'd1);
      // R7: nothing left
      idle_inputs(); open1(2, 8'h00); tick();
      chk("R7 refused request", {31'd0, grant[2]}, 32'd0);
      // R9: close frees at next edge; reopen on same edge is refused
      idle_inputs(); in_close[0] = 1'b1; open1(3, 8'h3F); tick();
      chk("R9 freed after close", {31'd0, out_used[1]}, 32'd0);
      chk("R9 freed port not reissued same edge", {31'd0, grant[3]}, 32'd0);
      close_all();

      // R1, R5, R6
      out_dis = 8'h08; out_busy = 8'h04; idle_inputs(); open1(3, 8'h5A);
      in_dis = 8'h10; open1(4, 8'h80); tick();
      chk("R1 low header bits ignored, dir 1", {31'd0, out_used[2]}, 32'd1);
      chk("R5 disabled output avoided", {31'd0, out_used[3]}, 32'd0);
      chk("R6 disabled input not granted", {31'd0, grant[4]}, 32'd0);
      close_all(); out_dis = '0; in_dis = '0;

      // R8: three requests for one direction
      out_busy = '0; idle_inputs(); open1(5, 8'hC0); open1(6, 8'hC1); open1(7, 8'hC2); tick();
      chk("R8 two lowest granted", {24'd0, grant}, 32'h60);
      chk("R8 both direction-3 ports used", {30'd0, out_used[7:6]}, 32'd3);
      close_all();

      // R10 / R4: zero seed becomes 01 -> upper; seed 02 -> lower
      idle_inputs(); seed_load = 1'b1; seed_val = 8'h00; tick();
      out_busy = 8'hFF; idle_inputs(); open1(0, 8'h40); tick();
      chk("R10 zero seed gives 01", {31'd0, out_used[3]}, 32'd1);
      chk("R4 equal hints, coin 1 -> upper", src_of(3), 32'd0);
      close_all();
      idle_inputs(); seed_load = 1'b1; seed_val = 8'h02; tick();
      idle_inputs(); open1(0, 8'h40); tick();
      chk("R4 equal hints, coin 0 -> lower", {31'd0, out_used[2]}, 32'd1);
      close_all();

      // R2 / R12: dual mode
      dil2_mode = 1'b0; out_busy = 8'h20; idle_inputs(); open1(4, 8'h40); open1(1, 8'h40); tick();
      chk("R12 busy ignored in dual mode", src_of(5), 32'd4);
      chk("R2 lower router direction 1", src_of(1), 32'd1);
      idle_inputs(); open1(4, 8'h80); tick();
      chk("R9 held input reopen ignored", {31'd0, out_used[6]}, 32'd0);
      close_all();

      // random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         dil2_mode = (c % 700) < 450;
         in_open  = 8'($urandom) & 8'($urandom);
         in_close = 8'($urandom) & 8'($urandom) & 8'($urandom);
         in_head  = {$urandom, $urandom};
         out_busy = 8'($urandom);
         in_dis   = 8'($urandom) & 8'($urandom) & 8'($urandom);
         out_dis  = 8'($urandom) & 8'($urandom) & 8'($urandom);
         seed_load = ($urandom % 50) == 0;
         seed_val  = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
         tick();
      end
      finish_run();
   end

endmodule